// File: doc/BRIEF.md
# Flat Single-Level Page Table Walker

This block translates device virtual addresses into physical addresses for one address space shared by every client. The translation table lives in memory as a flat array with one 32-bit entry for each 4 KB page, so a 4 GB virtual space needs 2^20 entries (4 MB). A lookup request carries a virtual address. The walker works out where that page's entry sits, issues a single memory read and decodes the returned word. It then answers with a physical address, or with a translation fault that is also reported on a separate fault interface.

The physical location of the table is set by a base register, written through a small register write port. Each write to the base register raises a one-cycle invalidate pulse, so that any entry cache placed around the walker can drop its stale translations. Only one lookup is in flight at a time.

Top module: `ptw_flat_walker`

## Requirements
- R1: The entry read address is the table base plus the virtual page number (virtual address bits 31..12) times four, taken modulo 2^32.
- R2: When bit 1 of the returned entry is set, the response carries no fault. Its physical address is entry bits 31..12 joined with virtual address bits 11..0, and its non-secure flag equals entry bit 3.
- R3: When bit 1 of the returned entry is clear, the response carries a fault with a physical address of zero and a non-secure flag of zero. This covers the all-zero (unmapped) entry as well as nonzero entries. In the same cycle a fault pulse reports the page-aligned virtual address and the raw entry.
- R4: Each accepted lookup issues exactly one memory read. Request ready stays low from acceptance until the response cycle, and is high in the response cycle.
- R5: The base register is at register offset 0 and resets to zero. A lookup made while it is zero still reads, starting at address 0. Writes to any other offset leave the base unchanged.
- R6: The invalidate output pulses for exactly one cycle, in the cycle after a write to the base register. Writes to other offsets do not pulse it.
- R7: While a memory read is pending and not yet accepted, the read valid stays high and the read address holds steady.
- R8: The response valid is a one-cycle pulse, in the cycle after the memory response is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| tlbInvalidate | output | 1 | One-cycle pulse after a table base change |
| reqValid | input | 1 | Lookup request valid |
| reqReady | output | 1 | Walker can accept a lookup |
| reqVa | input | 32 | Virtual address to translate |
| memRdValid | output | 1 | Entry read request |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | 32 | Entry byte address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry word |
| rspValid | output | 1 | Translation result valid |
| rspPa | output | 32 | Physical address |
| rspFault | output | 1 | Translation fault |
| rspNonSecure | output | 1 | Non-secure flag of the entry |
| faultValid | output | 1 | Fault report pulse |
| faultVa | output | 32 | Page-aligned faulting virtual address |
| faultEntry | output | 32 | Entry word that caused the fault |

## Verification
The case hardest to reach from the ports is a read held off by the memory for several cycles, followed by a slow response. Stalls in this window would reveal a second read, a drifting address or an early ready. The bench draws random stall and response delays for every lookup and checks the address and the ready state on each stalled cycle. Entries with bit 1 clear but other bits set, and base values close to the top of the address space that make the entry address wrap, are forced as directed cases.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // strobes from sequencing control into the datapath
  typedef struct packed {
    logic captureReq;  // latch VA and compute entry address
    logic takeEntry;   // decode returned entry and present response
  } ptw_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ptw_state_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memRdValid,
  input  logic        memRdReady,
  input  logic        memRspValid,
  output ptw_strobe_t strobe
);

  ptw_state_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    reqReady          = 1'b0;
    memRdValid        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.captureReq = 1'b1;
          stateNext         = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memRdValid = 1'b1;
        if (memRdReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.takeEntry = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // one read per lookup: an accepted read is never followed by another at once
  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && memRdReady |=> !memRdValid);

  // a lookup accepted drops ready in the next cycle
  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int VALID_BIT   = 1,
  parameter int NS_BIT      = 3,
  parameter int REG_AW      = 12,
  parameter int BASE_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              tlbInvalidate,
  input  logic [ADDR_W-1:0] reqVa,
  input  ptw_strobe_t       strobe,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPa,
  output logic              rspFault,
  output logic              rspNonSecure,
  output logic              faultValid,
  output logic [ADDR_W-1:0] faultVa,
  output logic [ENTRY_W-1:0] faultEntry
);

  localparam int VPN_W       = ADDR_W - PAGE_SHIFT;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] vaReg;
  logic [ADDR_W-1:0] entryAddr;
  logic [VPN_W-1:0]  vpn;
  logic              baseHit;
  logic              entryOk;
  logic [ADDR_W-1:0] decodedPa;

  assign baseHit = regWrEn && (regWrAddr == REG_AW'(BASE_OFFSET));
  assign vpn     = reqVa[ADDR_W-1:PAGE_SHIFT];

  // base register and invalidate hook
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg       <= '0;
      tlbInvalidate <= 1'b0;
    end else begin
      tlbInvalidate <= baseHit;
      if (baseHit) baseReg <= regWrData;
    end
  end

  // entry address computation at request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      entryAddr <= '0;
    end else if (strobe.captureReq) begin
      vaReg     <= reqVa;
      entryAddr <= baseReg + (ADDR_W'(vpn) << ENTRY_SHIFT);
    end
  end

  assign memRdAddr = entryAddr;

  // entry decode
  assign entryOk   = memRspData[VALID_BIT];
  assign decodedPa = {memRspData[ENTRY_W-1:PAGE_SHIFT], vaReg[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspPa        <= '0;
      rspFault     <= 1'b0;
      rspNonSecure <= 1'b0;
      faultValid   <= 1'b0;
      faultVa      <= '0;
      faultEntry   <= '0;
    end else begin
      rspValid   <= strobe.takeEntry;
      faultValid <= strobe.takeEntry && !entryOk;
      if (strobe.takeEntry) begin
        rspFault     <= !entryOk;
        rspPa        <= entryOk ? decodedPa : '0;
        rspNonSecure <= entryOk && memRspData[NS_BIT];
        faultVa      <= {vaReg[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        faultEntry   <= memRspData;
      end
    end
  end

  // a good translation keeps the page offset of the captured address
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspPa[PAGE_SHIFT-1:0] == vaReg[PAGE_SHIFT-1:0]);

  // invalidate follows a base write by one cycle
  assert_inval_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    baseHit |=> tlbInvalidate);

  // response is a single-cycle pulse
  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/ptw_flat_walker.sv
module ptw_flat_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int VALID_BIT   = 1,
  parameter int NS_BIT      = 3,
  parameter int REG_AW      = 12,
  parameter int BASE_OFFSET = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regWrAddr,
  input  logic [ADDR_W-1:0]  regWrData,
  output logic               tlbInvalidate,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqVa,
  output logic               memRdValid,
  input  logic               memRdReady,
  output logic [ADDR_W-1:0]  memRdAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  rspPa,
  output logic               rspFault,
  output logic               rspNonSecure,
  output logic               faultValid,
  output logic [ADDR_W-1:0]  faultVa,
  output logic [ENTRY_W-1:0] faultEntry
);

  ptw_strobe_t strobe;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memRdValid  (memRdValid),
    .memRdReady  (memRdReady),
    .memRspValid (memRspValid),
    .strobe      (strobe)
  );

  ptw_datapath #(
    .ADDR_W      (ADDR_W),
    .ENTRY_W     (ENTRY_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .VALID_BIT   (VALID_BIT),
    .NS_BIT      (NS_BIT),
    .REG_AW      (REG_AW),
    .BASE_OFFSET (BASE_OFFSET)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regWrAddr     (regWrAddr),
    .regWrData     (regWrData),
    .tlbInvalidate (tlbInvalidate),
    .reqVa         (reqVa),
    .strobe        (strobe),
    .memRdAddr     (memRdAddr),
    .memRspData    (memRspData),
    .rspValid      (rspValid),
    .rspPa         (rspPa),
    .rspFault      (rspFault),
    .rspNonSecure  (rspNonSecure),
    .faultValid    (faultValid),
    .faultVa       (faultVa),
    .faultEntry    (faultEntry)
  );

  // a stalled read keeps its request and address
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady |=> memRdValid && $stable(memRdAddr));

  // the fault report only accompanies a faulting response
  assert_fault_with_rsp_R3: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> rspValid && rspFault);

endmodule

// File: tb/ptw_flat_walker_tb.sv
module ptw_flat_walker_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [11:0] regWrAddr;
  logic [31:0] regWrData;
  logic        tlbInvalidate;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqVa;
  logic        memRdValid;
  logic        memRdReady;
  logic [31:0] memRdAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        rspValid;
  logic [31:0] rspPa;
  logic        rspFault;
  logic        rspNonSecure;
  logic        faultValid;
  logic [31:0] faultVa;
  logic [31:0] faultEntry;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expBase = 32'h0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ptw_flat_walker u_dut (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .tlbInvalidate(tlbInvalidate),
    .reqValid(reqValid), .reqReady(reqReady), .reqVa(reqVa),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault),
    .rspNonSecure(rspNonSecure),
    .faultValid(faultValid), .faultVa(faultVa), .faultEntry(faultEntry)
  );

  function automatic logic [31:0] expAddr(logic [31:0] base, logic [31:0] va);
    return base + {va[31:12], 2'b00};
  endfunction

  function automatic logic [31:0] expPa(logic [31:0] entry, logic [31:0] va);
    return entry[1] ? {entry[31:12], va[11:0]} : 32'h0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    if (addr == 12'h000) expBase = data;
    check(tlbInvalidate == (addr == 12'h000), "R6", "invalidate pulse",
          32'(tlbInvalidate), 32'(addr == 12'h000));
    @(negedge clk);
    check(tlbInvalidate == 1'b0, "R6", "invalidate single cycle", 32'(tlbInvalidate), 32'h0);
  endtask

  task automatic lookup(logic [31:0] va, logic [31:0] entry, int rdyDly, int rspDly);
    logic [31:0] ea;
    logic        ok;
    ea = expAddr(expBase, va);
    ok = entry[1];
    @(negedge clk);
    check(reqReady == 1'b1, "R4", "ready while idle", 32'(reqReady), 32'h1);
    reqValid = 1'b1; reqVa = va;
    @(negedge clk);
    reqValid = 1'b0; reqVa = $urandom;
    check(memRdValid == 1'b1, "R4", "read issued", 32'(memRdValid), 32'h1);
    check(memRdAddr == ea, "R1", "entry address", memRdAddr, ea);
    check(reqReady == 1'b0, "R4", "busy after accept", 32'(reqReady), 32'h0);
    for (int i = 0; i < rdyDly; i++) begin
      @(negedge clk);
      check(memRdValid == 1'b1 && memRdAddr == ea, "R7", "stalled read held", memRdAddr, ea);
    end
    memRdReady = 1'b1;
    @(negedge clk);
    memRdReady = 1'b0;
    check(memRdValid == 1'b0, "R4", "no second read", 32'(memRdValid), 32'h0);
    for (int i = 0; i < rspDly; i++) begin
      @(negedge clk);
      check(memRdValid == 1'b0 && reqReady == 1'b0 && rspValid == 1'b0, "R4",
            "idle wait for data", {29'h0, memRdValid, reqReady, rspValid}, 32'h0);
    end
    memRspValid = 1'b1; memRspData = entry;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = $urandom;
    check(rspValid == 1'b1, "R8", "response valid", 32'(rspValid), 32'h1);
    check(reqReady == 1'b1, "R4", "ready in response cycle", 32'(reqReady), 32'h1);
    check(rspFault == !ok, ok ? "R2" : "R3", "fault bit", 32'(rspFault), 32'(!ok));
    check(rspPa == expPa(entry, va), ok ? "R2" : "R3", "physical address", rspPa, expPa(entry, va));
    check(rspNonSecure == (ok && entry[3]), ok ? "R2" : "R3", "non-secure flag",
          32'(rspNonSecure), 32'(ok && entry[3]));
    check(faultValid == !ok, "R3", "fault pulse", 32'(faultValid), 32'(!ok));
    if (!ok) begin
      check(faultVa == {va[31:12], 12'h0}, "R3", "fault address", faultVa, {va[31:12], 12'h0});
      check(faultEntry == entry, "R3", "fault entry", faultEntry, entry);
    end
    @(negedge clk);
    check(rspValid == 1'b0 && faultValid == 1'b0, "R8", "response single cycle",
          {30'h0, rspValid, faultValid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd1234));
    rstN = 1'b0; regWrEn = 0; regWrAddr = 0; regWrData = 0;
    reqValid = 0; reqVa = 0; memRdReady = 0; memRspValid = 0; memRspData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && memRdValid == 1'b0 && rspValid == 1'b0 &&
          tlbInvalidate == 1'b0 && faultValid == 1'b0, "R5", "reset state",
          {27'h0, reqReady, memRdValid, rspValid, tlbInvalidate, faultValid}, 32'h10);
    // R5: zero base still reads, from address 0 upward
    lookup(32'h0000_0123, 32'h1234_5002, 0, 0);
    lookup(32'hABCD_E456, 32'h0, 1, 2);
    // R5: writes to other offsets leave base alone
    regWrite(12'h004, 32'h8000_0000);
    lookup(32'h0000_1FFF, 32'hFEDC_B00A, 2, 0);
    regWrite(12'h000, 32'h4000_0000);
    lookup(32'h0000_5ABC, 32'hFFFF_FFFD, 0, 1);        // R3 nonzero invalid
    lookup(32'hFFFF_FFFF, 32'h0001_200A, 3, 3);        // R2 offset 0xFFF, ns
    regWrite(12'h000, 32'hFFF0_0000);                  // R1 wrap
    lookup(32'hFFFF_F000, 32'h0000_3002, 1, 0);
    regWrite(12'h800, 32'h1111_1111);
    lookup(32'h0040_0000, 32'h0000_0008, 0, 0);        // R3 ns set, invalid
    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 7) regWrite(12'($urandom % 2 == 0 ? 0 : ($urandom % 4096)), $urandom);
      case ($urandom % 3)
        0: e = 32'h0;
        1: e = $urandom & 32'hFFFF_FFFD;
        default: e = $urandom | 32'h2;
      endcase
      lookup($urandom, e, int'($urandom % 5), int'($urandom % 5));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule